// File: doc/BRIEF.md
# Enhanced-Spectrum Grayscale PWM Controller

This block turns per-channel grayscale levels into on/off drive signals for a bank of channels. The channels are arranged in three colour groups: red, green and blue. A grayscale counter steps once per reference tick, and a full display period covers every counter value. The period is cut into equal segments. Each channel's on-time is not one contiguous pulse: every segment gets a base share of it. The leftover low-order counts add one extra tick to chosen segments, which are visited in bit-reversed segment order. The on-time is therefore spread evenly over the period, which raises the effective refresh rate seen by the eye.

The reference tick arrives as two single-cycle strobes, one for the rising edge and one for the falling edge of the tick. An edge-select input picks which strobe moves the counter and the outputs. The control inputs are:

- a blank input, which holds the counter at zero with every output dark;
- an auto-repeat input, which decides whether the period restarts or runs only once;
- a timing-reset input, which lets a latch-event strobe from the serial loader restart the period.

The output changes are staggered one system clock per colour group, so the groups never switch together.

Top module: `esp_pwm_ctrl`

## Requirements
- R1: After reset every channel output is 0, and the first counting tick evaluates counter value 0.
- R2: Channel n takes its level from `level_i[n*GS_W +: GS_W]` and belongs to group n mod NUM_GRP (0 red, 1 green, 2 blue). At counter value c, the segment is s = c >> (GS_W-SEG_BITS) and the position is p = c mod 2^(GS_W-SEG_BITS). The channel is on when p < (level >> SEG_BITS) + e, where e is 1 if the SEG_BITS-bit reversal of s is less than level mod 2^SEG_BITS, and 0 otherwise.
- R3: Level 0 never turns a channel on. Over one full period of 2^GS_W counting ticks, a channel is on for exactly `level` ticks. The all-ones level leaves the channel on for every tick except the last one of the final segment.
- R4: While `blank_i` is 1, the counter is held at 0 and every output goes to 0 within NUM_GRP+1 clocks. After blank is released, the next counting tick evaluates counter value 0.
- R5: With `repeat_i` at 1, the counter wraps from its last value to 0 and the pattern continues without a gap.
- R6: With `repeat_i` at 0 when the last counter value is evaluated, later counting ticks drive all outputs to 0. This lasts until blank is raised or a timing-reset latch event occurs.
- R7: A `latch_i` strobe while `tmgrst_i` is 1 resets the counter to 0 and forces all outputs to 0. The next counting tick starts a new period at counter value 0.
- R8: A `latch_i` strobe while `tmgrst_i` is 0 changes neither the counter nor the outputs.
- R9: With `edge_sel_i` at 1, only `ref_rise_i` steps the counter and updates the outputs. With `edge_sel_i` at 0, only `ref_fall_i` does. The other strobe leaves both unchanged.
- R10: Take the clock edge that samples a stepping strobe or a resetting latch. The red outputs take the new value 1 clock after that edge, green 2 clocks after it, and blue 3 clocks after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_i | input | 1 | Holds the counter at zero and darkens all outputs |
| repeat_i | input | 1 | 1: period restarts; 0: single period |
| tmgrst_i | input | 1 | 1: a latch event restarts the period |
| edge_sel_i | input | 1 | 1: step on rising strobe; 0: step on falling strobe |
| ref_rise_i | input | 1 | One-clock strobe for the reference tick rising edge |
| ref_fall_i | input | 1 | One-clock strobe for the reference tick falling edge |
| latch_i | input | 1 | One-clock latch-event strobe from the serial loader |
| level_i | input | NUM_GRP*CH_PER_GRP*GS_W | Grayscale levels, channel n at bits n*GS_W and up |
| ch_on_o | output | NUM_GRP*CH_PER_GRP | Registered channel on/off drives |

## Verification
The bench builds the block with GS_W=6, SEG_BITS=3 and one channel per group. That gives 8 segments of 8 ticks and a 64-tick period. Every level from 0 to 63 can then be swept through a whole period on all three channels, checking each tick against the arithmetic rule and each period's on-count against the level. The short period also makes it cheap to cover repeat wrap-around, the one-shot stop, latch events with and without timing reset, both edge selections and the per-group stagger after every tick.

// File: rtl/esp_pkg.sv
package esp_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } ref_edge_e;

  localparam int GRP_RED   = 0;
  localparam int GRP_GREEN = 1;
  localparam int GRP_BLUE  = 2;
endpackage

// File: rtl/esp_tick_counter.sv
module esp_tick_counter #(
  parameter int GS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            blank_i,
  input  logic            repeat_i,
  input  logic            tmgrst_i,
  input  logic            edge_sel_i,
  input  logic            ref_rise_i,
  input  logic            ref_fall_i,
  input  logic            latch_i,
  output logic [GS_W-1:0] cnt_o,
  output logic            eval_o,
  output logic            clear_o
);
  import esp_pkg::*;

  localparam logic [GS_W-1:0] CNT_LAST = '1;

  logic [GS_W-1:0] cnt_q;
  logic            done_q;
  logic            step;
  logic            restart;

  always_comb begin
    step    = (ref_edge_e'(edge_sel_i) == EDGE_RISE) ? ref_rise_i : ref_fall_i;
    restart = latch_i & tmgrst_i;
    eval_o  = step & ~blank_i & ~restart & ~done_q;
    clear_o = blank_i | restart | (step & done_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (blank_i || restart) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (eval_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST && !repeat_i) done_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/esp_chan_cmp.sv
module esp_chan_cmp #(
  parameter int GS_W     = 16,
  parameter int SEG_BITS = 7
) (
  input  logic [GS_W-1:0] level_i,
  input  logic [GS_W-1:0] cnt_i,
  output logic            on_o
);
  localparam int POS_W = GS_W - SEG_BITS;

  logic [SEG_BITS-1:0] seg;
  logic [SEG_BITS-1:0] seg_rev;
  logic [SEG_BITS-1:0] spare;
  logic [POS_W-1:0]    pos;
  logic [POS_W-1:0]    base;
  logic [POS_W:0]      limit;

  assign seg   = cnt_i[GS_W-1 -: SEG_BITS];
  assign pos   = cnt_i[POS_W-1:0];
  assign base  = level_i[GS_W-1 -: POS_W];
  assign spare = level_i[SEG_BITS-1:0];

  for (genvar i = 0; i < SEG_BITS; i++) begin : g_rev
    assign seg_rev[i] = seg[SEG_BITS-1-i];
  end

  assign limit = {1'b0, base} + {{POS_W{1'b0}}, (seg_rev < spare)};
  assign on_o  = ({1'b0, pos} < limit);
endmodule

// File: rtl/esp_grp_delay.sv
module esp_grp_delay #(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/esp_pwm_ctrl.sv
module esp_pwm_ctrl #(
  parameter int GS_W       = 16,
  parameter int SEG_BITS   = 7,
  parameter int NUM_GRP    = 3,
  parameter int CH_PER_GRP = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 blank_i,
  input  logic                                 repeat_i,
  input  logic                                 tmgrst_i,
  input  logic                                 edge_sel_i,
  input  logic                                 ref_rise_i,
  input  logic                                 ref_fall_i,
  input  logic                                 latch_i,
  input  logic [NUM_GRP*CH_PER_GRP*GS_W-1:0]   level_i,
  output logic [NUM_GRP*CH_PER_GRP-1:0]        ch_on_o
);
  localparam int NCH = NUM_GRP * CH_PER_GRP;

  logic [GS_W-1:0] cnt_q;
  logic            eval;
  logic            clear;
  logic [NCH-1:0]  on_vec;
  logic [NCH-1:0]  pwm_q;

  esp_tick_counter #(.GS_W(GS_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .blank_i    (blank_i),
    .repeat_i   (repeat_i),
    .tmgrst_i   (tmgrst_i),
    .edge_sel_i (edge_sel_i),
    .ref_rise_i (ref_rise_i),
    .ref_fall_i (ref_fall_i),
    .latch_i    (latch_i),
    .cnt_o      (cnt_q),
    .eval_o     (eval),
    .clear_o    (clear)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    esp_chan_cmp #(.GS_W(GS_W), .SEG_BITS(SEG_BITS)) u_cmp (
      .level_i (level_i[n*GS_W +: GS_W]),
      .cnt_i   (cnt_q),
      .on_o    (on_vec[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        pwm_q <= '0;
    else if (clear) pwm_q <= '0;
    else if (eval)  pwm_q <= on_vec;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [CH_PER_GRP-1:0] grp_d;
    logic [CH_PER_GRP-1:0] grp_q;

    for (genvar k = 0; k < CH_PER_GRP; k++) begin : g_map
      assign grp_d[k]                 = pwm_q[k*NUM_GRP + g];
      assign ch_on_o[k*NUM_GRP + g]   = grp_q[k];
    end

    esp_grp_delay #(.W(CH_PER_GRP), .DEPTH(g + 1)) u_dly (
      .clk (clk),
      .rst (rst),
      .d_i (grp_d),
      .q_o (grp_q)
    );
  end
endmodule

// File: rtl/esp_pwm_chk.sv
module esp_pwm_chk #(
  parameter int GS_W    = 16,
  parameter int NCH     = 12,
  parameter int NUM_GRP = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            blank_i,
  input logic            tmgrst_i,
  input logic            edge_sel_i,
  input logic            ref_rise_i,
  input logic            ref_fall_i,
  input logic            latch_i,
  input logic [GS_W-1:0] cnt_i,
  input logic [NCH-1:0]  ch_on_i
);
  localparam int RUN_LIM = NUM_GRP + 1;
  localparam int RUN_W   = $clog2(RUN_LIM + 1);

  logic [RUN_W-1:0] run_q;
  logic             sel;

  assign sel = edge_sel_i ? ref_rise_i : ref_fall_i;

  always_ff @(posedge clk) begin
    if (rst || !blank_i)                 run_q <= '0;
    else if (run_q < RUN_W'(RUN_LIM))    run_q <= run_q + 1'b1;
  end

  // R4
  blank_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    blank_i |=> cnt_i == '0);

  // R4
  blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q >= RUN_W'(RUN_LIM)) |-> ch_on_i == '0);

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_i && tmgrst_i) |=> cnt_i == '0);

  // R8
  latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_i && !tmgrst_i && !blank_i && !sel) |=> $stable(cnt_i));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_i && !latch_i && !sel) |=> $stable(cnt_i));
endmodule

bind esp_pwm_ctrl esp_pwm_chk #(
  .GS_W    (GS_W),
  .NCH     (NUM_GRP * CH_PER_GRP),
  .NUM_GRP (NUM_GRP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .blank_i    (blank_i),
  .tmgrst_i   (tmgrst_i),
  .edge_sel_i (edge_sel_i),
  .ref_rise_i (ref_rise_i),
  .ref_fall_i (ref_fall_i),
  .latch_i    (latch_i),
  .cnt_i      (cnt_q),
  .ch_on_i    (ch_on_o)
);

// File: tb/tb_esp_pwm_ctrl.sv
module tb_esp_pwm_ctrl;
  localparam int GS_W     = 6;
  localparam int SEG_BITS = 3;
  localparam int NCH      = 3;
  localparam int LAST     = (1 << GS_W) - 1;
  localparam int POS_MSK  = (1 << (GS_W - SEG_BITS)) - 1;
  localparam int SEG_MSK  = (1 << SEG_BITS) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blank_i = 1'b0, repeat_i = 1'b1, tmgrst_i = 1'b0, edge_sel_i = 1'b1;
  logic ref_rise_i = 1'b0, ref_fall_i = 1'b0, latch_i = 1'b0;
  logic [NCH*GS_W-1:0] level_i = '0;
  logic [NCH-1:0] ch_on_o;

  always #2 clk = ~clk;

  esp_pwm_ctrl #(.GS_W(GS_W), .SEG_BITS(SEG_BITS), .NUM_GRP(3), .CH_PER_GRP(1)) dut (
    .clk(clk), .rst(rst), .blank_i(blank_i), .repeat_i(repeat_i), .tmgrst_i(tmgrst_i),
    .edge_sel_i(edge_sel_i), .ref_rise_i(ref_rise_i), .ref_fall_i(ref_fall_i),
    .latch_i(latch_i), .level_i(level_i), .ch_on_o(ch_on_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int mcnt = 0;
  bit mdone = 1'b0;
  logic [NCH-1:0] exp_q = '0;
  int lvl [NCH];
  int sums [NCH];

  function automatic bit model_on(int lv, int c);
    int seg = c >> (GS_W - SEG_BITS);
    int pos = c & POS_MSK;
    int rv = 0;
    for (int i = 0; i < SEG_BITS; i++)
      if (seg[i]) rv |= 1 << (SEG_BITS - 1 - i);
    return pos < ((lv >> SEG_BITS) + ((rv < (lv & SEG_MSK)) ? 1 : 0));
  endfunction

  task automatic check(string tag, logic [NCH-1:0] act, logic [NCH-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: ch_on=%b expected %b (count %0d)", tag, act, expv, mcnt);
    end
  endtask

  task automatic set_levels(int a, int b, int c);
    @(negedge clk);
    lvl[0] = a; lvl[1] = b; lvl[2] = c;
    level_i = {GS_W'(c), GS_W'(b), GS_W'(a)};
  endtask

  task automatic set_blank(bit b);
    @(negedge clk);
    blank_i = b;
    repeat (5) @(negedge clk);
    if (b) begin
      mcnt = 0; mdone = 1'b0; exp_q = '0;
    end
    check("R4", ch_on_o, exp_q);
  endtask

  // kind 0: rising strobe, 1: falling strobe, 2: latch event
  task automatic do_evt(int kind, string tag);
    logic [NCH-1:0] prev, nxt;
    bit step;
    prev = exp_q;
    nxt = exp_q;
    step = 1'b0;
    @(negedge clk);
    if (kind == 0) ref_rise_i = 1'b1;
    else if (kind == 1) ref_fall_i = 1'b1;
    else latch_i = 1'b1;
    if (!blank_i) begin
      if (kind == 2) begin
        if (tmgrst_i) begin
          nxt = '0; mcnt = 0; mdone = 1'b0;
        end
      end else if ((kind == 0) == edge_sel_i) begin
        step = 1'b1;
        if (mdone) nxt = '0;
        else begin
          for (int c = 0; c < NCH; c++) nxt[c] = model_on(lvl[c], mcnt);
          if (mcnt == LAST) begin
            mcnt = 0;
            if (!repeat_i) mdone = 1'b1;
          end else mcnt++;
        end
      end
    end
    exp_q = nxt;
    @(negedge clk);
    ref_rise_i = 1'b0; ref_fall_i = 1'b0; latch_i = 1'b0;
    @(negedge clk);
    check({tag, "/R10 red"}, ch_on_o, {prev[2], prev[1], nxt[0]});
    @(negedge clk);
    check({tag, "/R10 green"}, ch_on_o, {prev[2], nxt[1], nxt[0]});
    @(negedge clk);
    check({tag, "/R10 blue"}, ch_on_o, nxt);
    if (step) for (int c = 0; c < NCH; c++) sums[c] += int'(ch_on_o[c]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin lvl[c] = 0; sums[c] = 0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", ch_on_o, '0);
    set_levels(63, 9, 1);
    do_evt(0, "R1");

    // R2 R3 R9: every level over a full period, falling strobe ignored
    edge_sel_i = 1'b1; repeat_i = 1'b1; tmgrst_i = 1'b0;
    for (int v = 0; v <= LAST; v++) begin
      set_levels(v, LAST - v, (v * 37) & LAST);
      set_blank(1'b1);
      set_blank(1'b0);
      for (int c = 0; c < NCH; c++) sums[c] = 0;
      for (int t = 0; t <= LAST; t++) begin
        do_evt(0, "R2");
        do_evt(1, "R9");
      end
      for (int c = 0; c < NCH; c++) begin
        n_chk++;
        if (sums[c] != lvl[c]) begin
          n_fail++;
          $display("FAIL R3: ch%0d on-ticks %0d expected %0d", c, sums[c], lvl[c]);
        end
      end
    end

    // R9: falling strobe selected
    set_levels(45, 18, 7);
    edge_sel_i = 1'b0;
    set_blank(1'b1); set_blank(1'b0);
    for (int t = 0; t < 20; t++) begin
      do_evt(0, "R9");
      do_evt(1, "R9");
    end
    edge_sel_i = 1'b1;

    // R5: wrap-around continues
    set_blank(1'b1); set_blank(1'b0);
    for (int t = 0; t < 80; t++) do_evt(0, "R5");

    // R6: single period then dark; R7 restart by latch
    repeat_i = 1'b0;
    set_blank(1'b1); set_blank(1'b0);
    for (int t = 0; t < 70; t++) do_evt(0, "R6");
    check("R6", ch_on_o, '0);
    tmgrst_i = 1'b1;
    do_evt(2, "R7");
    for (int t = 0; t < 10; t++) do_evt(0, "R7");

    // R8: latch without timing reset
    repeat_i = 1'b1; tmgrst_i = 1'b0;
    set_blank(1'b1); set_blank(1'b0);
    for (int t = 0; t < 20; t++) do_evt(0, "R8");
    do_evt(2, "R8");
    for (int t = 0; t < 10; t++) do_evt(0, "R8");

    // R7: latch with timing reset mid-period
    tmgrst_i = 1'b1;
    for (int t = 0; t < 15; t++) do_evt(0, "R7");
    do_evt(2, "R7");
    for (int t = 0; t < 12; t++) do_evt(0, "R7");

    // R4: strobes during blank have no effect
    set_blank(1'b1);
    for (int t = 0; t < 4; t++) do_evt(0, "R4");
    set_blank(1'b0);
    do_evt(0, "R4");

    summary();
    $finish;
  end
endmodule